// File: doc/BRIEF.md
# Shared-Bus SRAM/Flash Interface Controller

This block sits between a synchronous host port and an asynchronous 32-bit memory bus. Two banks share that bus: one SRAM bank and one flash bank, each made of four byte-wide dies. The host asks for a read or a write. Each request carries a bank select, a 19-bit address, a 4-bit byte mask and, for a write, 32 bits of data. The controller then drives the memory strobes. The bus has one chip enable per bank, one output enable that both banks share, and a separate write enable for each byte lane of each bank. Every strobe width and gap is counted in clock cycles. Each count comes from a nanosecond figure divided by the clock period and rounded up.

The sequence is driven by a state machine with five named states:

- `ST_IDLE`: waits for a request and is the only state that accepts one.
- `ST_SETUP`: drives the address and the selected chip enable while every strobe stays inactive.
- `ST_STROBE`: pulses the byte write enables for a write, or holds the output enable low for a read.
- `ST_HOLD`: used by writes only. The write enables return high while the address, chip enable and data stay steady.
- `ST_RECOVER`: deselects both banks and releases the bus.

The transitions are:

- `ST_IDLE` to `ST_SETUP` when a request is valid.
- `ST_SETUP` to `ST_STROBE` when the setup count expires.
- `ST_STROBE` to `ST_HOLD` for a write, or to `ST_RECOVER` for a read, when the strobe count expires.
- `ST_HOLD` to `ST_RECOVER` when the hold count expires.
- `ST_RECOVER` to `ST_IDLE` when the recovery count expires.

A one-cycle done pulse ends every transaction. For a read, the captured data is presented with that pulse.

Top module: `dualbank_bus_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `req_ready` is 1. Both chip enables, the output enable and all eight write enables are 1 (inactive). `mem_dq_oe` is 0 and `rsp_done` is 0.
- R2: A request is taken only on a rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only in `ST_IDLE`. Changes on the request inputs while a transaction runs have no effect on `mem_addr` or on any strobe.
- R3: The two chip enables are never low together. Only the chip enable of the selected bank (`req_bank` 0 = SRAM, 1 = flash) goes low, from the first `ST_SETUP` cycle to the last `ST_STROBE` or `ST_HOLD` cycle.
- R4: In `ST_SETUP` the address is valid and the chip enable is low, while the output enable and all write enables stay high. This lasts SU cycles.
- R5: In a write's `ST_STROBE`, lane i of the selected bank has its write enable low exactly when byte mask bit i is 1. Bit 0 is data bits 7:0. The other bank's write enables stay high. The pulse lasts PW cycles.
- R6: In a write's `ST_HOLD`, all write enables are high, while the chip enable, address and `mem_dq_out` stay unchanged for HO cycles.
- R7: In a read, the output enable is low for RD cycles. The bus is sampled on the edge that ends the last of them. `rsp_done` is 1 for exactly one cycle, the first `ST_RECOVER` cycle, and `rsp_rdata` then holds the sampled word.
- R8: `mem_dq_oe` is 1 only during a write's `ST_SETUP`, `ST_STROBE` and `ST_HOLD`. It is never 1 while the output enable is low, nor in the cycle after one with the output enable low.
- R9: In `ST_RECOVER` both chip enables are high and the bus is released, for RC cycles. The state then returns to `ST_IDLE`.
- R10: A write also ends with a one-cycle `rsp_done` in its first `ST_RECOVER` cycle.
- R11: Phase lengths use ceil(ns / CLK_NS), with a floor of 1.
  - SU = ceil(address setup).
  - PW = ceil(max(write pulse, data setup)).
  - HO = max(1, ceil(write cycle or address hold) − SU − PW for SRAM, or − PW for flash).
  - RD = ceil(max(address access, output-enable access)).
  - RC = ceil(max(high-Z release, pulse high time)).
  - At 20 ns the SRAM takes SU/PW/HO/RD/RC = 1/1/1/2/1 cycles and the flash 1/2/1/3/1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | 0 = SRAM bank, 1 = flash bank |
| req_addr | input | 19 | Word address |
| req_be | input | 4 | Byte-lane mask for writes |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 32 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 32 | Data returned from the memory bus |
| mem_sram_ce_n | output | 1 | SRAM bank chip enable, active low |
| mem_flash_ce_n | output | 1 | Flash bank chip enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_sram_we_n | output | 4 | SRAM per-lane write enables, active low |
| mem_flash_we_n | output | 4 | Flash per-lane write enables, active low |

## Verification
A wrong state or a wrong phase count shows at the pins within the same cycle. A strobe appears one cycle early or late, a chip enable lingers into recovery, or the done pulse lands in the wrong cycle. For that reason every strobe, enable, address and data pin is compared cycle by cycle against a timeline computed from the phase formulas. A wrong captured word is visible only in the done cycle. So reads on both banks use an address-dependent memory model, and every bad bank or address mux changes the returned word.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOVER
    } dbc_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never less than one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbc_phase_timer.sv
module dbc_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dbc_lane_strobe.sv
module dbc_lane_strobe #(
    parameter int LANES = 4
) (
    input  logic             strobe,
    input  logic             bank,
    input  logic [LANES-1:0] lane_mask,
    output logic [LANES-1:0] sram_we_n,
    output logic [LANES-1:0] flash_we_n
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic pulse;
        assign pulse         = strobe && lane_mask[g];
        assign sram_we_n[g]  = !(pulse && !bank);
        assign flash_we_n[g] = !(pulse && bank);
    end

endmodule

// File: rtl/dualbank_bus_ctrl.sv
module dualbank_bus_ctrl #(
    parameter int CLK_NS    = 20,
    parameter int ADDR_W    = 19,
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter int SR_AS_NS  = 2,
    parameter int SR_WP_NS  = 17,
    parameter int SR_DW_NS  = 13,
    parameter int SR_WC_NS  = 25,
    parameter int SR_AA_NS  = 25,
    parameter int SR_OE_NS  = 12,
    parameter int SR_HZ_NS  = 12,
    parameter int FL_AS_NS  = 0,
    parameter int FL_WP_NS  = 40,
    parameter int FL_DS_NS  = 40,
    parameter int FL_AH_NS  = 45,
    parameter int FL_WPH_NS = 20,
    parameter int FL_ACC_NS = 60,
    parameter int FL_OE_NS  = 30,
    parameter int FL_DF_NS  = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic                    req_bank,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES-1:0]        req_be,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    output logic                    rsp_done,
    output logic [LANES*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [LANES*LANE_W-1:0] mem_dq_in,
    output logic                    mem_sram_ce_n,
    output logic                    mem_flash_ce_n,
    output logic                    mem_oe_n,
    output logic [LANES-1:0]        mem_sram_we_n,
    output logic [LANES-1:0]        mem_flash_we_n
);
    import dbc_pkg::*;

    localparam int DATA_W = LANES * LANE_W;

    // Phase lengths in cycles, per bank.
    localparam int SR_SU = ns2cyc(SR_AS_NS, CLK_NS);
    localparam int SR_PW = ns2cyc(imax(SR_WP_NS, SR_DW_NS), CLK_NS);
    localparam int SR_HO = imax(1, ns2cyc(SR_WC_NS, CLK_NS) - SR_SU - SR_PW);
    localparam int SR_RD = ns2cyc(imax(SR_AA_NS, SR_OE_NS), CLK_NS);
    localparam int SR_RC = ns2cyc(SR_HZ_NS, CLK_NS);
    localparam int FL_SU = ns2cyc(FL_AS_NS, CLK_NS);
    localparam int FL_PW = ns2cyc(imax(FL_WP_NS, FL_DS_NS), CLK_NS);
    localparam int FL_HO = imax(1, ns2cyc(FL_AH_NS, CLK_NS) - FL_PW);
    localparam int FL_RD = ns2cyc(imax(FL_ACC_NS, FL_OE_NS), CLK_NS);
    localparam int FL_RC = ns2cyc(imax(FL_WPH_NS, FL_DF_NS), CLK_NS);

    localparam int MAX_A   = imax(imax(SR_SU, SR_PW), imax(SR_HO, imax(SR_RD, SR_RC)));
    localparam int MAX_B   = imax(imax(FL_SU, FL_PW), imax(FL_HO, imax(FL_RD, FL_RC)));
    localparam int MAX_DUR = imax(MAX_A, MAX_B);
    localparam int CNT_W   = imax(1, $clog2(MAX_DUR + 1));

    dbc_state_e state_q, state_d;

    logic                bank_q, write_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [LANES-1:0]    be_q;
    logic [DATA_W-1:0]   wdata_q, rdata_q;
    logic                done_q;
    logic                sel_bank, sel_write;
    logic                tmr_load, tmr_expired;
    logic [CNT_W-1:0]    tmr_val;
    logic                active, we_strobe;

    // Next-state decision.
    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)   state_d = ST_SETUP;
            ST_SETUP:   if (tmr_expired) state_d = ST_STROBE;
            ST_STROBE:  if (tmr_expired) state_d = write_q ? ST_HOLD : ST_RECOVER;
            ST_HOLD:    if (tmr_expired) state_d = ST_RECOVER;
            ST_RECOVER: if (tmr_expired) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Bank and direction of the transaction being entered or running.
    assign sel_bank  = (state_q == ST_IDLE) ? req_bank  : bank_q;
    assign sel_write = (state_q == ST_IDLE) ? req_write : write_q;

    // Length of the phase about to start.
    always_comb begin : phase_len
        int len;
        len = 1;
        unique case (state_d)
            ST_SETUP:   len = sel_bank ? FL_SU : SR_SU;
            ST_STROBE:  len = sel_write ? (sel_bank ? FL_PW : SR_PW)
                                        : (sel_bank ? FL_RD : SR_RD);
            ST_HOLD:    len = sel_bank ? FL_HO : SR_HO;
            ST_RECOVER: len = sel_bank ? FL_RC : SR_RC;
            default:    len = 1;
        endcase
        tmr_val  = CNT_W'(len - 1);
        tmr_load = (state_d != state_q);
    end

    dbc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, read capture and completion pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q  <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE && req_valid) begin
                bank_q  <= req_bank;
                write_q <= req_write;
                addr_q  <= req_addr;
                be_q    <= req_be;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_STROBE && tmr_expired && !write_q) begin
                rdata_q <= mem_dq_in;
                done_q  <= 1'b1;
            end
            if (state_q == ST_HOLD && tmr_expired) begin
                done_q <= 1'b1;
            end
        end
    end

    // Output decode from state.
    always_comb begin : outputs
        active         = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        we_strobe      = (state_q == ST_STROBE) && write_q;
        mem_sram_ce_n  = !(active && !bank_q);
        mem_flash_ce_n = !(active && bank_q);
        mem_oe_n       = !((state_q == ST_STROBE) && !write_q);
        mem_dq_oe      = active && write_q;
        mem_addr       = addr_q;
        mem_dq_out     = wdata_q;
        req_ready      = (state_q == ST_IDLE);
        rsp_done       = done_q;
        rsp_rdata      = rdata_q;
    end

    dbc_lane_strobe #(.LANES(LANES)) u_lanes (
        .strobe     (we_strobe),
        .bank       (bank_q),
        .lane_mask  (be_q),
        .sram_we_n  (mem_sram_we_n),
        .flash_we_n (mem_flash_we_n)
    );

    // R3
    ce_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_sram_ce_n && !mem_flash_ce_n));

    // R8
    bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> !mem_dq_oe);

    // R5
    sram_we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sram_we_n != '1) |-> (!mem_sram_ce_n && mem_dq_oe));

    // R5
    flash_we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_flash_we_n != '1) |-> (!mem_flash_ce_n && mem_dq_oe));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

    // R9
    recover_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (mem_sram_ce_n && mem_flash_ce_n && !mem_dq_oe));

endmodule

// File: tb/tb_dualbank_bus_ctrl.sv
module tb_dualbank_bus_ctrl;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
    logic [18:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_done, mem_dq_oe;
    logic [31:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [18:0] mem_addr;
    logic        mem_sram_ce_n, mem_flash_ce_n, mem_oe_n;
    logic [3:0]  mem_sram_we_n, mem_flash_we_n;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dualbank_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_sram_ce_n(mem_sram_ce_n), .mem_flash_ce_n(mem_flash_ce_n),
        .mem_oe_n(mem_oe_n), .mem_sram_we_n(mem_sram_we_n),
        .mem_flash_we_n(mem_flash_we_n)
    );

    function automatic logic [31:0] pat(input logic bank, input logic [18:0] a);
        return {a[12:0], a} ^ (bank ? 32'hF0F0_1234 : 32'h0F0F_4321);
    endfunction

    // Memory model: each bank returns an address-dependent word when selected.
    assign mem_dq_in = !mem_flash_ce_n ? pat(1'b1, mem_addr) :
                       !mem_sram_ce_n  ? pat(1'b0, mem_addr) : 32'hDEAD_BEEF;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(tag, {31'd0, req_ready}, 32'd1);
        chk(tag, {27'd0, mem_sram_ce_n, mem_flash_ce_n, mem_oe_n, mem_dq_oe, rsp_done},
            {27'd0, 5'b11100});
        chk(tag, {24'd0, mem_sram_we_n, mem_flash_we_n}, 32'h0000_00FF);
    endtask

    // Runs one transaction; called at a falling edge while the block is idle.
    task automatic run_txn(input logic wr, input logic bank, input logic [18:0] addr,
                           input logic [3:0] be, input logic [31:0] wd);
        int su, pl, ho, rc, total;
        string ph_tag;
        su = bank ? cdiv(0) : cdiv(2);
        if (wr) begin
            pl = bank ? cdiv(mx(40, 40)) : cdiv(mx(17, 13));
            ho = bank ? mx(1, cdiv(45) - pl) : mx(1, cdiv(25) - su - pl);
        end else begin
            pl = bank ? cdiv(mx(60, 30)) : cdiv(mx(25, 12));
            ho = 0;
        end
        rc = bank ? cdiv(mx(20, 20)) : cdiv(12);
        total = su + pl + ho + rc;

        chk("R2 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_bank = bank;
        req_addr = addr; req_be = be; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        // Junk on the request port while busy must be ignored.
        req_write = ~wr; req_bank = ~bank; req_addr = ~addr;
        req_be = ~be; req_wdata = ~wd;
        for (int i = 0; i < total; i++) begin
            logic act, strobe;
            logic [3:0] exp_ws, exp_wf;
            if (i == total - 1) req_valid = 1'b0;
            act    = (i < su + pl + ho);
            strobe = (i >= su) && (i < su + pl);
            ph_tag = (i < su) ? "R4" : strobe ? (wr ? "R5" : "R7") : act ? "R6" : "R9";
            chk("R3 chip enables", {30'd0, mem_sram_ce_n, mem_flash_ce_n},
                {30'd0, !(act && !bank), !(act && bank)});
            chk(ph_tag, {31'd0, mem_oe_n}, {31'd0, !(!wr && strobe)});
            exp_ws = (wr && strobe && !bank) ? ~be : 4'hF;
            exp_wf = (wr && strobe && bank)  ? ~be : 4'hF;
            chk(ph_tag, {24'd0, mem_sram_we_n, mem_flash_we_n}, {24'd0, exp_ws, exp_wf});
            chk("R8 bus drive", {31'd0, mem_dq_oe}, {31'd0, wr && act});
            if (wr && act) chk("R6 write data", mem_dq_out, wd);
            if (act) chk("R2 address held", {13'd0, mem_addr}, {13'd0, addr});
            chk("R2 busy not ready", {31'd0, req_ready}, 32'd0);
            chk(wr ? "R10 done timing" : "R7 done timing", {31'd0, rsp_done},
                {31'd0, i == su + pl + ho});
            if (!wr && i == su + pl + ho) chk("R7 read data", rsp_rdata, pat(bank, addr));
            @(negedge clk);
        end
        chk("R11 back to idle", {31'd0, req_ready}, 32'd1);
        chk("R9 released", {30'd0, mem_sram_ce_n, mem_flash_ce_n}, {30'd0, 2'b11});
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog act=running exp=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        // Writes: every byte mask on both banks.
        for (int b = 0; b < 2; b++) begin
            for (int m = 0; m < 16; m++) begin
                run_txn(1'b1, b[0], 19'((m * 19'h1357 + b * 19'h2468) & 19'h7FFFF),
                        m[3:0], 32'hC0DE_0000 ^ (m * 32'h0101_0101) ^ (b * 32'h8000_0001));
            end
        end
        // Reads, including the address extremes, alternating with writes.
        for (int k = 0; k < 8; k++) begin
            for (int b = 0; b < 2; b++) begin
                logic [18:0] a;
                a = (k == 0) ? 19'h00000 : (k == 7) ? 19'h7FFFF : 19'(k * 19'h0ABCD);
                run_txn(1'b0, b[0], a, 4'hF, 32'h0);
                run_txn(1'b1, ~b[0], a, 4'(k), 32'h1234_5678 + k);
            end
        end
        report();
    end

endmodule